// File: doc/BRIEF.md
# Multi-Chip Memory Bank

This block presents one flat, word-wide memory built out of several identical smaller memory chips. A single address bus, a read enable, a write enable, a write data bus and a read data bus form the whole interface. Inside, the chips are grouped into sets. The chips of one set sit side by side, so together they span the full access width. Each set holds a different range of the address space.

The geometry is derived from a handful of parameters: the addressable unit, the access width, the chip data width, the chip address width and the total chip count. From these the block works out how many chips form a set, how many sets exist, how many upper address bits pick the set and how many lower address bits are dropped because the access is wider than the addressable unit. The upper bits drive a set decoder. The middle bits go in parallel to every chip's address input. Each chip is modelled as a small synchronous array, so a read returns its word one clock after the request.

Top module: `mbank_top`

## Requirements
- R1: The memory stores SETS*2^CHIP_AW independent words, with SETS = NUM_CHIPS/(ACC_W/CHIP_W). Each distinct word address keeps its own value.
- R2: The top SET_BITS = log2(SETS) address bits select exactly one set for a read or write. In an idle cycle or a conflict cycle, no set is selected.
- R3: The CHIP_AW address bits just below the set bits select the word inside every chip of the chosen set.
- R4: The lowest LOW_BITS = log2(ACC_W/UNIT_W) address bits are ignored. Two addresses that differ only in those bits reach the same word.
- R5: All ACC_W bits of a written word are returned unchanged by a later read of that word. Chip k of a set holds bits k*CHIP_W and up.
- R6: Operations are coded as {rd_en,wr_en}: 00 idle, 01 write, 10 read, 11 not allowed. A read gives rd_valid=1 and the stored word on rd_data in the cycle after the request.
- R7: In any cycle that does not follow a read request, rd_valid is 0 and rd_data is all zero.
- R8: A request with both enables high writes nothing and reads nothing. In the following cycle conflict is 1; conflict is 0 after any other request.
- R9: While rst_n is low, and right after it rises, rd_valid and conflict are 0 and rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Address in addressable units |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| wr_data | input | ACC_W | Word to write |
| rd_data | output | ACC_W | Word read, zero when no read completes |
| rd_valid | output | 1 | rd_data holds a read result |
| conflict | output | 1 | Previous request had both enables set |

## Verification
A wrong set decode or a wrong chip address split shows up as aliasing: a read returns a word written at a different address. This appears on the first read of an affected word, so the bench fills every word before it runs random traffic. A misplaced chip lane corrupts only a slice of the returned word. A broken low-bit drop makes neighbouring unit addresses diverge. A leaky conflict path changes memory contents, and this only becomes visible at the next read of that word, which is why every conflict test is followed by a read-back.

// File: rtl/mbank_pkg.sv
package mbank_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_BAD   = 2'b11
    } op_e;

    function automatic op_e op_from_enables(input logic rd, input logic wr);
        return op_e'({rd, wr});
    endfunction

    function automatic int unsigned safe_log2(input int unsigned v);
        return (v > 1) ? $clog2(v) : 0;
    endfunction

endpackage

// File: rtl/mbank_addr_split.sv
module mbank_addr_split #(
    parameter int ADDR_W   = 8,
    parameter int SET_BITS = 2,
    parameter int CHIP_AW  = 4,
    parameter int LOW_BITS = 2,
    localparam int SEL_W   = (SET_BITS > 0) ? SET_BITS : 1
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [SEL_W-1:0]   set_idx,
    output logic [CHIP_AW-1:0] chip_addr
);
    // chip address field sits right above the dropped low bits (R3, R4)
    assign chip_addr = addr[LOW_BITS +: CHIP_AW];

    generate
        if (SET_BITS > 0) begin : g_sel
            assign set_idx = addr[ADDR_W-1 -: SET_BITS];   // R2: top bits
        end else begin : g_nosel
            assign set_idx = '0;
        end
        if (LOW_BITS > 0) begin : g_low
            logic unused_low_bits;
            assign unused_low_bits = ^addr[LOW_BITS-1:0];  // R4: dropped
        end
    endgenerate
endmodule

// File: rtl/mbank_set_decode.sv
module mbank_set_decode #(
    parameter int SETS  = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] set_idx,
    output logic [SETS-1:0]  cs
);
    always_comb begin
        cs = '0;
        for (int s = 0; s < SETS; s++) begin
            if (en && (set_idx == SEL_W'(s))) cs[s] = 1'b1;
        end
    end

    p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs));
    p_cs_one_when_used_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ($countones(cs) == 1));
    p_cs_none_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (cs == '0));
endmodule

// File: rtl/mbank_chip.sv
module mbank_chip #(
    parameter int AW = 4,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          re,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    typedef struct packed {
        logic [DW-1:0] dout;
    } chip_state_t;

    logic [DW-1:0] mem [DEPTH];
    chip_state_t   st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs && re && !we) st_d.dout = mem[addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (cs && we && !re) mem[addr] <= din;
    end

    assign dout = st_q.dout;

    // R8: the bank never presents a read-and-write pair to a chip
    p_chip_no_dual_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs |-> !(re && we));
endmodule

// File: rtl/mbank_top.sv
module mbank_top
    import mbank_pkg::*;
#(
    parameter int UNIT_W    = 8,
    parameter int ACC_W     = 32,
    parameter int CHIP_W    = 8,
    parameter int CHIP_AW   = 4,
    parameter int NUM_CHIPS = 16,
    localparam int CPS      = ACC_W / CHIP_W,
    localparam int SETS     = NUM_CHIPS / CPS,
    localparam int SET_BITS = safe_log2(SETS),
    localparam int LOW_BITS = safe_log2(ACC_W / UNIT_W),
    localparam int SEL_W    = (SET_BITS > 0) ? SET_BITS : 1,
    localparam int ADDR_W   = SET_BITS + CHIP_AW + LOW_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ACC_W-1:0]  wr_data,
    output logic [ACC_W-1:0]  rd_data,
    output logic              rd_valid,
    output logic              conflict
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             valid;
        logic             conflict;
    } top_state_t;

    op_e              op;
    logic [SEL_W-1:0] set_idx;
    logic [CHIP_AW-1:0] chip_addr;
    logic [SETS-1:0]  cs;
    logic             do_rd, do_wr;
    logic [ACC_W-1:0] set_word [SETS];
    top_state_t       st_d, st_q;

    assign op    = op_from_enables(rd_en, wr_en);
    assign do_rd = (op == OP_READ);
    assign do_wr = (op == OP_WRITE);

    mbank_addr_split #(
        .ADDR_W(ADDR_W), .SET_BITS(SET_BITS),
        .CHIP_AW(CHIP_AW), .LOW_BITS(LOW_BITS)
    ) u_split (
        .addr(addr), .set_idx(set_idx), .chip_addr(chip_addr)
    );

    mbank_set_decode #(.SETS(SETS), .SEL_W(SEL_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .en(do_rd || do_wr),
        .set_idx(set_idx), .cs(cs)
    );

    generate
        for (genvar s = 0; s < SETS; s++) begin : g_set
            for (genvar k = 0; k < CPS; k++) begin : g_lane
                // lane k carries word bits k*CHIP_W upward (R5)
                mbank_chip #(.AW(CHIP_AW), .DW(CHIP_W)) u_chip (
                    .clk(clk), .rst_n(rst_n), .cs(cs[s]),
                    .re(do_rd), .we(do_wr), .addr(chip_addr),
                    .din(wr_data[k*CHIP_W +: CHIP_W]),
                    .dout(set_word[s][k*CHIP_W +: CHIP_W])
                );
            end
        end
    endgenerate

    always_comb begin
        st_d          = st_q;
        st_d.valid    = do_rd;
        st_d.conflict = (op == OP_BAD);
        if (do_rd) st_d.sel = set_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (st_q.valid) begin
            for (int s = 0; s < SETS; s++) begin
                if (st_q.sel == SEL_W'(s)) rd_data = set_word[s];
            end
        end
    end

    assign rd_valid = st_q.valid;
    assign conflict = st_q.conflict;

    p_read_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> rd_valid);
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !wr_en) |=> (!rd_valid && rd_data == '0));
    p_conflict_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> conflict);
    p_conflict_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en) |=> !conflict);
endmodule

// File: tb/mbank_top_tb.sv
module mbank_top_tb;
    localparam int ACC_W  = 32;
    localparam int LOW    = 2;
    localparam int ADDR_W = 8;
    localparam int WORDS  = 1 << (ADDR_W - LOW);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              rd_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [ACC_W-1:0]  wr_data = '0;
    logic [ACC_W-1:0]  rd_data;
    logic              rd_valid;
    logic              conflict;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;
    logic [ACC_W-1:0] ref_mem [WORDS];

    always #10 clk = ~clk;   // 50 MHz

    mbank_top #(
        .UNIT_W(8), .ACC_W(ACC_W), .CHIP_W(8), .CHIP_AW(4), .NUM_CHIPS(16)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .conflict(conflict)
    );

    task automatic compare(input string tag, input logic [ACC_W-1:0] ed,
                           input logic ev, input logic ec);
        vectors++;
        if (rd_data !== ed || rd_valid !== ev || conflict !== ec) begin
            miscompares++;
            $display("FAIL %s: data=%h valid=%b conflict=%b expected data=%h valid=%b conflict=%b",
                     tag, rd_data, rd_valid, conflict, ed, ev, ec);
        end
    endtask

    // one request per cycle; called at a falling edge, returns at the next one
    task automatic step(input logic re, input logic we, input logic [ADDR_W-1:0] a,
                        input logic [ACC_W-1:0] d, input string tag);
        logic [ACC_W-1:0] ed;
        logic ev, ec;
        int idx;
        rd_en = re; wr_en = we; addr = a; wr_data = d;
        @(posedge clk);
        idx = int'(a >> LOW);
        ev  = re && !we;
        ec  = re && we;
        ed  = ev ? ref_mem[idx] : '0;
        if (we && !re) ref_mem[idx] = d;
        @(negedge clk);
        compare(tag, ed, ev, ec);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R9 in reset", '0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R9 after reset", '0, 1'b0, 1'b0);

        // R1, R3, R5: fill every word with a distinct full-width pattern, read all back
        for (int w = 0; w < WORDS; w++)
            step(1'b0, 1'b1, ADDR_W'(w << LOW), {8'(w), 8'(~w), 8'(w ^ 8'h5A), 8'(w + 3)}, "R1 fill");
        for (int w = 0; w < WORDS; w++)
            step(1'b1, 1'b0, ADDR_W'(w << LOW), '0, "R1 R5 readback");

        // R2: words differing only in set bits stay separate
        for (int s = 0; s < 4; s++)
            step(1'b0, 1'b1, ADDR_W'((s << 6) | 8'h14), 32'hC0DE_0000 | s, "R2 write");
        for (int s = 0; s < 4; s++)
            step(1'b1, 1'b0, ADDR_W'((s << 6) | 8'h14), '0, "R2 read");

        // R4: low unit bits are dropped
        step(1'b0, 1'b1, 8'h58, 32'hA5A5_1234, "R4 write");
        for (int l = 0; l < 4; l++)
            step(1'b1, 1'b0, ADDR_W'(8'h58 | l), '0, "R4 alias read");
        step(1'b0, 1'b1, 8'h9F, 32'h0F0F_F0F0, "R4 write high low-bits");
        step(1'b1, 1'b0, 8'h9C, '0, "R4 alias read");

        // R8: conflict writes nothing and raises the flag
        step(1'b0, 1'b1, 8'h24, 32'h1111_2222, "R8 setup");
        step(1'b1, 1'b1, 8'h24, 32'hDEAD_BEEF, "R8 conflict");
        step(1'b1, 1'b0, 8'h24, '0, "R8 readback");
        step(1'b1, 1'b1, 8'h24, 32'h0, "R8 back-to-back conflict");
        step(1'b1, 1'b1, 8'hE0, 32'h0, "R8 back-to-back conflict");

        // R7: idle after read returns zeros
        step(1'b1, 1'b0, 8'h24, '0, "R6 read");
        step(1'b0, 1'b0, 8'h24, '0, "R7 idle");
        step(1'b0, 1'b0, 8'h00, '0, "R7 idle");

        // R6: random traffic against the flat model
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom_range(0, 9);
            if (r < 4)       step(1'b1, 1'b0, ADDR_W'($urandom), '0, "R6 random read");
            else if (r < 8)  step(1'b0, 1'b1, ADDR_W'($urandom), $urandom, "R6 random write");
            else if (r == 8) step(1'b0, 1'b0, ADDR_W'($urandom), $urandom, "R7 random idle");
            else             step(1'b1, 1'b1, ADDR_W'($urandom), $urandom, "R8 random conflict");
        end
        for (int w = 0; w < WORDS; w++)
            step(1'b1, 1'b0, ADDR_W'((w << LOW) | (w & 3)), '0, "R1 R4 final sweep");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule